// File: doc/BRIEF.md
# Memory Bus Control Packet Generator

This block drives the serial bus-enable line that carries control packets to the memory devices on a shared bus. A two-bit operating mode sets the packet cadence. In reset cadence, packets run back to back with no gap. Holding that cadence long enough resets every device on the bus. In active cadence, one packet starts at a fixed period, which keeps the devices awake. In standby cadence, a packet is sent only when the transaction engine strobes a start, and a one-cycle ready pulse follows the packet's last bit. The fourth encoding is reserved, and the line stays quiet in it.

Each packet is a fixed serial pattern of `PKT_LEN` bits, shifted out least significant bit first. A separate timer counts consecutive cycles spent in reset cadence and raises a flag once the device reset time has elapsed. Two enable inputs let the transmit and receive front-ends be stopped while the bus is idle. When an enable is low, its path is kept awake.

The sequencer has four states:
- `ST_OFF`: nothing is sent.
- `ST_SEND`: bits are shifted out.
- `ST_GAP`: the pause that fills the rest of an active-cadence period.
- `ST_READY`: the cycle in which the ready pulse is given.

Transitions:
- `ST_OFF`→`ST_SEND` happens on reset or active cadence, or on a start strobe in standby.
- `ST_SEND`→`ST_SEND` happens on its last bit in reset cadence, which restarts the packet.
- `ST_SEND`→`ST_GAP` happens on the last bit in active cadence.
- `ST_SEND`→`ST_READY` happens on the last bit of a strobe-requested packet in standby.
- `ST_SEND`→`ST_OFF` happens on the last bit of any other packet in standby.
- `ST_GAP`→`ST_SEND` happens at the end of the period, or at once when the mode becomes reset.
- `ST_GAP`→`ST_OFF` happens when the mode becomes standby.
- `ST_READY`→`ST_OFF` always happens.
- Any state→`ST_OFF` happens when the reserved mode is seen.

Top module: `busctl_pkt_gen`

## Requirements
- R1: While `rst_n` is low, `bus_en`, `pkt_start`, `txn_ready` and `rst_done` are 0, and `tx_stop` and `rx_stop` are 1.
- R2: With `op_mode`=00 (reset cadence), packets follow one another with no gap. `bus_en` repeats the pattern 1,1,0 (`PKT_PATTERN`=3'b011, LSB first), and `pkt_start` pulses on the first bit of every packet.
- R3: `rst_done` is low after 271 consecutive clock edges that sample `op_mode`=00 and high after the 272nd. It then stays high while the mode stays 00.
- R4: Any edge that samples `op_mode`≠00 clears the counter, and `rst_done` is low after that edge. A later return to 00 needs a fresh full run of 272 edges.
- R5: With `op_mode`=01 (active cadence), a packet starts every 4 cycles. `bus_en` shows 1,1,0,0 per period.
- R6: With `op_mode`=10 (standby), a `txn_start` sampled while the generator is in `ST_OFF` puts the first bit on `bus_en` in the next cycle. `txn_ready` is high for exactly the one cycle after the last bit.
- R7: In standby, no packet is sent without a strobe. A `txn_start` that arrives while a packet is in flight is ignored and gives no second packet.
- R8: An edge that samples `op_mode`=11 forces `bus_en` and `pkt_start` low from the next cycle, and aborts any packet in flight.
- R9: `tx_stop` is 1 after an edge where `tx_pd_en`=1, `bus_idle`=1 and the generator's next state is `ST_OFF`; otherwise it is 0. With `tx_pd_en`=0 it is always 0.
- R10: `rx_stop` is 1 after an edge that samples both `rx_pd_en`=1 and `bus_idle`=1; otherwise it is 0.
- R11: A change among modes 00, 01 and 10 in the middle of a packet lets that packet finish. A packet that was not requested by a strobe gives no ready pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_mode | input | 2 | Cadence: 00 reset, 01 active, 10 standby, 11 reserved |
| tx_pd_en | input | 1 | Enables transmit stop while idle |
| rx_pd_en | input | 1 | Enables receive stop while idle |
| txn_start | input | 1 | Transaction-start strobe from the transaction engine |
| bus_idle | input | 1 | High when no transfer uses the bus |
| bus_en | output | 1 | Serial control packet line |
| pkt_start | output | 1 | High on the first bit of each packet |
| txn_ready | output | 1 | One-cycle pulse after a requested packet completes |
| tx_stop | output | 1 | Stops the transmit front-end |
| rx_stop | output | 1 | Stops the receive front-end |
| rst_done | output | 1 | Reset cadence has been held for the device reset time |

## Verification
The embedded properties watch several local rules on every cycle:
- the reserved mode silences the line;
- reset cadence restarts a packet straight after its last bit;
- an active-cadence gap ends in a new packet;
- standby never transmits unprompted;
- ready only follows a sending cycle;
- the reset flag drops as soon as the mode leaves reset and holds while it stays there;
- each stop output stays low whenever its enable is low.

Only the bench's scenarios can show the whole-sequence behaviour:
- the exact bit pattern and cadence over many periods;
- the 271/272-edge boundary of the reset timer and its restart after a mode change;
- a start strobe being ignored mid-packet;
- a packet finishing across a mode switch;
- the cycle-exact interplay of the transmit stop with a packet that is about to begin.

// File: rtl/busctl_pkg.sv
package busctl_pkg;

    typedef enum logic [1:0] {
        MODE_RESET   = 2'b00,
        MODE_ACTIVE  = 2'b01,
        MODE_STANDBY = 2'b10,
        MODE_RSVD    = 2'b11
    } bus_mode_e;

    typedef enum logic [1:0] {
        ST_OFF,
        ST_SEND,
        ST_GAP,
        ST_READY
    } seq_state_e;

endpackage

// File: rtl/busctl_seq_fsm.sv
module busctl_seq_fsm
    import busctl_pkg::*;
#(
    parameter int              PKT_LEN     = 3,
    parameter logic [PKT_LEN-1:0] PKT_PATTERN = 3'b011,
    parameter int              ACT_PERIOD  = 4
) (
    input  logic      clk,
    input  logic      rst_n,
    input  bus_mode_e mode,
    input  logic      txn_start,
    output logic      bus_en_o,
    output logic      pkt_start_o,
    output logic      txn_ready_o,
    output logic      idle_next_o
);

    localparam int SPAN  = (ACT_PERIOD > PKT_LEN) ? ACT_PERIOD : PKT_LEN;
    localparam int CYC_W = $clog2(SPAN + 1);
    localparam logic [CYC_W-1:0] LAST_BIT = CYC_W'(PKT_LEN - 1);
    localparam logic [CYC_W-1:0] LAST_CYC = CYC_W'(ACT_PERIOD - 1);
    localparam bit HAS_GAP = (ACT_PERIOD > PKT_LEN);

    seq_state_e           state_q, state_d;
    logic [CYC_W-1:0]     cyc_q, cyc_d;
    logic                 req_q, req_d;
    logic [PKT_LEN-1:0]   shreg_q;
    logic                 last_bit;

    assign last_bit = (cyc_q == LAST_BIT);

    // next-state logic
    always_comb begin
        state_d = state_q;
        cyc_d   = cyc_q;
        req_d   = req_q;
        if (mode == MODE_RSVD) begin
            state_d = ST_OFF;
            cyc_d   = '0;
            req_d   = 1'b0;
        end else begin
            unique case (state_q)
                ST_OFF: begin
                    cyc_d = '0;
                    req_d = 1'b0;
                    if (mode == MODE_RESET || mode == MODE_ACTIVE) begin
                        state_d = ST_SEND;
                    end else if (txn_start) begin
                        state_d = ST_SEND;
                        req_d   = 1'b1;
                    end
                end
                ST_SEND: begin
                    if (!last_bit) begin
                        cyc_d = cyc_q + 1'b1;
                    end else if (mode == MODE_RESET) begin
                        state_d = ST_SEND;
                        cyc_d   = '0;
                        req_d   = 1'b0;
                    end else if (mode == MODE_ACTIVE) begin
                        req_d = 1'b0;
                        if (HAS_GAP) begin
                            state_d = ST_GAP;
                            cyc_d   = cyc_q + 1'b1;
                        end else begin
                            state_d = ST_SEND;
                            cyc_d   = '0;
                        end
                    end else begin
                        state_d = req_q ? ST_READY : ST_OFF;
                        cyc_d   = '0;
                    end
                end
                ST_GAP: begin
                    if (mode == MODE_ACTIVE) begin
                        if (cyc_q == LAST_CYC) begin
                            state_d = ST_SEND;
                            cyc_d   = '0;
                        end else begin
                            cyc_d = cyc_q + 1'b1;
                        end
                    end else if (mode == MODE_RESET) begin
                        state_d = ST_SEND;
                        cyc_d   = '0;
                    end else begin
                        state_d = ST_OFF;
                        cyc_d   = '0;
                    end
                end
                ST_READY: begin
                    state_d = ST_OFF;
                    cyc_d   = '0;
                    req_d   = 1'b0;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            cyc_q   <= '0;
            req_q   <= 1'b0;
            shreg_q <= '0;
        end else begin
            state_q <= state_d;
            cyc_q   <= cyc_d;
            req_q   <= req_d;
            if (state_d == ST_SEND && cyc_d == '0) begin
                shreg_q <= PKT_PATTERN;
            end else if (state_q == ST_SEND) begin
                shreg_q <= shreg_q >> 1;
            end
        end
    end

    // outputs
    always_comb begin
        bus_en_o    = (state_q == ST_SEND) && shreg_q[0];
        pkt_start_o = (state_q == ST_SEND) && (cyc_q == '0);
        txn_ready_o = (state_q == ST_READY);
        idle_next_o = (state_d == ST_OFF);
    end

    AST_RSVD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_RSVD) |=> (!bus_en_o && !pkt_start_o)); // R8

    AST_RST_BACK2BACK: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SEND && last_bit && mode == MODE_RESET) |=> pkt_start_o); // R2

    AST_GAP_RESUMES: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GAP && cyc_q == LAST_CYC && mode == MODE_ACTIVE) |=> pkt_start_o); // R5

    AST_STBY_NO_SPONT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OFF && mode == MODE_STANDBY && !txn_start) |=> !bus_en_o); // R7

    AST_READY_AFTER_PKT: assert property (@(posedge clk) disable iff (!rst_n)
        txn_ready_o |-> $past(state_q == ST_SEND)); // R6

endmodule

// File: rtl/busctl_rst_timer.sv
module busctl_rst_timer
    import busctl_pkg::*;
#(
    parameter int RST_HOLD = 272
) (
    input  logic      clk,
    input  logic      rst_n,
    input  bus_mode_e mode,
    output logic      rst_done_o
);

    localparam int CNT_W = $clog2(RST_HOLD + 1);
    localparam logic [CNT_W-1:0] HOLD_MAX = CNT_W'(RST_HOLD);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (mode != MODE_RESET) begin
            cnt_q <= '0;
        end else if (cnt_q != HOLD_MAX) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign rst_done_o = (cnt_q == HOLD_MAX);

    AST_DONE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != MODE_RESET) |=> !rst_done_o); // R4

    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_done_o && mode == MODE_RESET) |=> rst_done_o); // R3

endmodule

// File: rtl/busctl_pwr_gate.sv
module busctl_pwr_gate #(
    parameter int LANES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] pd_en,
    input  logic [LANES-1:0] quiet,
    output logic [LANES-1:0] stop_o
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic stop_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stop_q <= 1'b1;
            end else begin
                stop_q <= pd_en[g] & quiet[g];
            end
        end

        assign stop_o[g] = stop_q;

        AST_AWAKE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
            !pd_en[g] |=> !stop_o[g]); // R9 R10
    end

endmodule

// File: rtl/busctl_pkt_gen.sv
module busctl_pkt_gen
    import busctl_pkg::*;
#(
    parameter int                 PKT_LEN     = 3,
    parameter logic [PKT_LEN-1:0] PKT_PATTERN = 3'b011,
    parameter int                 ACT_PERIOD  = 4,
    parameter int                 RST_HOLD    = 272
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] op_mode,
    input  logic       tx_pd_en,
    input  logic       rx_pd_en,
    input  logic       txn_start,
    input  logic       bus_idle,
    output logic       bus_en,
    output logic       pkt_start,
    output logic       txn_ready,
    output logic       tx_stop,
    output logic       rx_stop,
    output logic       rst_done
);

    localparam int LANE_TX = 0;
    localparam int LANE_RX = 1;

    bus_mode_e  mode;
    logic       gen_idle_next;
    logic [1:0] lane_en, lane_quiet, lane_stop;

    assign mode = bus_mode_e'(op_mode);

    busctl_seq_fsm #(
        .PKT_LEN    (PKT_LEN),
        .PKT_PATTERN(PKT_PATTERN),
        .ACT_PERIOD (ACT_PERIOD)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (mode),
        .txn_start  (txn_start),
        .bus_en_o   (bus_en),
        .pkt_start_o(pkt_start),
        .txn_ready_o(txn_ready),
        .idle_next_o(gen_idle_next)
    );

    busctl_rst_timer #(
        .RST_HOLD(RST_HOLD)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .rst_done_o(rst_done)
    );

    assign lane_en[LANE_TX]    = tx_pd_en;
    assign lane_en[LANE_RX]    = rx_pd_en;
    assign lane_quiet[LANE_TX] = bus_idle & gen_idle_next;
    assign lane_quiet[LANE_RX] = bus_idle;

    busctl_pwr_gate #(
        .LANES(2)
    ) u_pwr (
        .clk   (clk),
        .rst_n (rst_n),
        .pd_en (lane_en),
        .quiet (lane_quiet),
        .stop_o(lane_stop)
    );

    assign tx_stop = lane_stop[LANE_TX];
    assign rx_stop = lane_stop[LANE_RX];

endmodule

// File: tb/busctl_pkt_gen_tb.sv
module busctl_pkt_gen_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] op_mode = 2'b00;
    logic       tx_pd_en = 1'b0;
    logic       rx_pd_en = 1'b0;
    logic       txn_start = 1'b0;
    logic       bus_idle = 1'b0;
    logic       bus_en, pkt_start, txn_ready, tx_stop, rx_stop, rst_done;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [5:0] exp;
        string      req;
    } item_t;

    item_t sb_q[$];

    always #10 clk = ~clk;

    busctl_pkt_gen u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_mode  (op_mode),
        .tx_pd_en (tx_pd_en),
        .rx_pd_en (rx_pd_en),
        .txn_start(txn_start),
        .bus_idle (bus_idle),
        .bus_en   (bus_en),
        .pkt_start(pkt_start),
        .txn_ready(txn_ready),
        .tx_stop  (tx_stop),
        .rx_stop  (rx_stop),
        .rst_done (rst_done)
    );

    function automatic logic [5:0] observed();
        return {bus_en, pkt_start, txn_ready, rst_done, tx_stop, rx_stop};
    endfunction

    task automatic check(input logic [5:0] act, input logic [5:0] exp, input string req);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: {bus_en,pkt_start,ready,done,tx_stop,rx_stop} actual %b expected %b",
                     req, act, exp);
        end
    endtask

    // driver: apply inputs for one cycle, queue the result expected after the edge
    task automatic step(input logic [1:0] m, input logic ts, input logic idl,
                        input logic tp, input logic rp,
                        input logic eb, input logic eps, input logic erdy,
                        input logic edone, input logic etx, input logic erx,
                        input string req);
        item_t it;
        @(negedge clk);
        op_mode   = m;
        txn_start = ts;
        bus_idle  = idl;
        tx_pd_en  = tp;
        rx_pd_en  = rp;
        it.exp = {eb, eps, erdy, edone, etx, erx};
        it.req = req;
        sb_q.push_back(it);
    endtask

    // monitor: compare after each edge, away from it
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                check(observed(), it.exp, it.req);
            end
        end
    end

    // pattern bits LSB first: 1,1,0
    function automatic logic pat_bit(input int ph);
        return (ph != 2);
    endfunction

    initial begin
        #(200000 * 20);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        // R1: reset state, even with reset cadence requested
        repeat (3) @(negedge clk);
        check(observed(), 6'b000011, "R1");
        op_mode = 2'b11;
        @(negedge clk);
        check(observed(), 6'b000011, "R1");
        rst_n = 1'b1;

        // R6 / R7: standby with strobe; second strobe mid-packet ignored
        step(2'b10, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R7 no strobe");
        step(2'b10, 1, 0, 0, 0, 1, 1, 0, 0, 0, 0, "R6 first bit");
        step(2'b10, 1, 0, 0, 0, 1, 0, 0, 0, 0, 0, "R7 strobe mid-packet");
        step(2'b10, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R6 last bit");
        step(2'b10, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, "R6 ready");
        step(2'b10, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R6 ready single");
        step(2'b10, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R7 no second packet");

        // R5: active cadence, period 4
        for (int k = 0; k < 8; k++) begin
            step(2'b01, 0, 0, 0, 0, pat_bit(k % 4 == 3 ? 2 : k % 4), (k % 4) == 0,
                 0, 0, 0, 0, "R5");
        end
        // R11: switch to standby mid-packet, packet completes, no ready
        step(2'b01, 0, 0, 0, 0, 1, 1, 0, 0, 0, 0, "R5 restart");
        step(2'b10, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, "R11 continue");
        step(2'b10, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R11 last bit");
        step(2'b10, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R11 no ready");
        step(2'b10, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R11 stays off");

        // R2 / R3: reset cadence from idle
        for (int i = 0; i < 275; i++) begin
            step(2'b00, 0, 0, 0, 0, pat_bit(i % 3), (i % 3) == 0, 0,
                 (i + 1) >= 272, 0, 0, (i == 270 || i == 271) ? "R3 boundary" : "R2");
        end
        // R4: leave reset cadence (phase now at bit 1)
        step(2'b01, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R4 clear");
        step(2'b01, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R4 gap");
        step(2'b01, 0, 0, 0, 0, 1, 1, 0, 0, 0, 0, "R5 after reset cadence");
        for (int j = 0; j < 272; j++) begin
            step(2'b00, 0, 0, 0, 0, pat_bit((1 + j) % 3), ((1 + j) % 3) == 0, 0,
                 j >= 271, 0, 0, (j >= 270) ? "R4 restart boundary" : "R2 rerun");
        end
        // R8: reserved silences the line and clears the flag
        step(2'b11, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R8");
        step(2'b11, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R8 hold");

        // R9 / R10: powerdown
        step(2'b10, 0, 1, 1, 1, 0, 0, 0, 0, 1, 1, "R9 R10 idle stop");
        step(2'b10, 0, 0, 1, 1, 0, 0, 0, 0, 0, 0, "R9 R10 busy bus");
        step(2'b10, 1, 1, 1, 1, 1, 1, 0, 0, 0, 1, "R9 packet starting");
        step(2'b10, 0, 1, 1, 1, 1, 0, 0, 0, 0, 1, "R9 sending");
        step(2'b10, 0, 1, 1, 1, 0, 0, 0, 0, 0, 1, "R9 last bit");
        step(2'b10, 0, 1, 1, 1, 0, 0, 1, 0, 0, 1, "R9 ready cycle");
        step(2'b10, 0, 1, 1, 1, 0, 0, 0, 0, 1, 1, "R9 back to idle");
        step(2'b10, 0, 1, 0, 1, 0, 0, 0, 0, 0, 1, "R9 tx disabled");
        step(2'b10, 0, 1, 1, 0, 0, 0, 0, 0, 1, 0, "R10 rx disabled");
        step(2'b00, 0, 1, 1, 0, 1, 1, 0, 0, 0, 0, "R9 reset cadence awake");
        step(2'b00, 0, 1, 1, 0, 1, 0, 0, 0, 0, 0, "R9 reset cadence awake");

        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule